// File: doc/BRIEF.md
# Cascaded 16-bit match interval timer

This block is a periodic interval timer. Two 8-bit counting stages are chained into one 16-bit up-counter. The counter advances on a source tick picked from a free-running prescaler and is compared against a 16-bit match value that software loads one byte at a time. When a tick arrives while the count equals the match value, the count returns to zero, a one-cycle interrupt pulse is raised and a sticky interrupt flag is set. The timer then keeps running, so the interrupt repeats at a fixed interval.

All logic runs on the system clock. The prescaler turns that clock into single-cycle tick enables. Four fast taps divide the system clock, and a slow tick is derived from a slow reference enable. The 2-bit source select, the divider-mode bit and the low-power input together pick the tick. The match register has no shadow copy, so a byte write changes the compare value in the very next cycle. Software loads the upper byte first and the lower byte second.

Top module: `cascade_match_timer`

## Requirements
- R1: After reset the count is 0, the interrupt pulse and the sticky flag are 0, and the match value is 0xFFFF.
- R2: While `run_en` is 0 the count is forced to 0 on the next clock and stays there, and no interrupt is raised.
- R3: While `run_en` is 1 the count rises by exactly one on each selected tick and holds in every other cycle.
- R4: On a tick where the count equals the match value, the count goes to 0 and `irq_pulse` is 1 for exactly that one following cycle. Pulses therefore repeat every (match+1) ticks.
- R5: A write with `wr_hi` replaces match bits 15:8, and a write with `wr_lo` replaces bits 7:0. The new value is compared from the next cycle on, even while the timer runs.
- R6: With `low_power`=0, select values 3, 2 and 1 give a tick every 2^SH3, 2^SH2 and 2^SH1 system clocks. Select 0 with `div_mode`=0 gives a tick every 2^SH0 clocks (defaults 8, 32, 128, 2048).
- R7: With `div_mode`=1 and `low_power`=0, select 0 gives the slow tick, one every 8 slow reference periods (8*SLOW_RATIO clocks). Selects 1 to 3 are unchanged.
- R8: With `low_power`=1, select 0 gives the slow tick and selects 1 to 3 give no tick, so the count stays unchanged.
- R9: `irq_flag` is set by every match event and cleared by `irq_clr`. When both happen in the same cycle, the set wins.
- R10: If the match value is written below the current count, the counter runs on to 0xFFFF, wraps to 0 and then matches normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Run control; 0 holds the count at zero |
| src_sel | input | 2 | Source tick select |
| div_mode | input | 1 | Replaces select 0 with the slow tick |
| low_power | input | 1 | Low-power mode; only select 0 (slow tick) counts |
| wr_hi | input | 1 | Write strobe for match bits 15:8 |
| wr_lo | input | 1 | Write strobe for match bits 7:0 |
| wr_data | input | 8 | Byte written to the match register |
| irq_clr | input | 1 | Clears the sticky flag |
| irq_pulse | output | 1 | One-cycle interrupt on each match |
| irq_flag | output | 1 | Sticky interrupt flag |
| count | output | 16 | Current counter value |

## Verification
The bench drives a run-time rewrite of the match value and a rewrite below the current count. A design that latched the match value, or cleared on a greater-or-equal compare, would fire at the wrong count instead of 0x30 or instead of after the wrap through 0xFFFF. It measures the gap between pulses for every fast tap, for the slow tick in both divider mode and low-power mode, and for a low-power select that must freeze the count. An off-by-one in the match-and-clear path would show up as a gap of match ticks instead of match+1. A set-versus-clear priority slip on the flag shows up when `irq_clr` is held through a pulse.

// File: rtl/cmt_pkg.sv
package cmt_pkg;

    typedef struct packed {
        logic [7:0] hi;
        logic [7:0] lo;
    } match_bytes_t;

    typedef enum logic [1:0] {
        SRC_TAP0 = 2'd0,
        SRC_TAP1 = 2'd1,
        SRC_TAP2 = 2'd2,
        SRC_TAP3 = 2'd3
    } src_sel_e;

    // Pick the active tick enable from the fast taps and the slow tick.
    function automatic logic pick_tick(input logic [3:0] fast_taps,
                                       input logic       slow_tick,
                                       input src_sel_e   sel,
                                       input logic       div_mode,
                                       input logic       low_power);
        logic t;
        if (low_power)
            t = (sel == SRC_TAP0) ? slow_tick : 1'b0;
        else if (sel == SRC_TAP0)
            t = div_mode ? slow_tick : fast_taps[0];
        else
            t = fast_taps[sel];
        return t;
    endfunction

endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
    import cmt_pkg::*;
#(
    parameter int unsigned SH0        = 11,
    parameter int unsigned SH1        = 7,
    parameter int unsigned SH2        = 5,
    parameter int unsigned SH3        = 3,
    parameter int unsigned SLOW_RATIO = 488,
    parameter int unsigned SLOW_SH    = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  src_sel_e sel,
    input  logic     div_mode,
    input  logic     low_power,
    output logic     tick
);
    localparam int unsigned DIV_W  = SH0;
    localparam int unsigned PRE_W  = (SLOW_RATIO > 1) ? $clog2(SLOW_RATIO) : 1;
    localparam int unsigned SHV [4] = '{SH0, SH1, SH2, SH3};

    logic [DIV_W-1:0]   fast_q;
    logic [PRE_W-1:0]   pre_q;
    logic [SLOW_SH-1:0] slow_q;
    logic [3:0]         fast_taps;
    logic               fs_edge;
    logic               slow_tick;

    always_ff @(posedge clk) begin
        if (rst) fast_q <= '0;
        else     fast_q <= fast_q + 1'b1;
    end

    for (genvar i = 0; i < 4; i++) begin : g_tap
        localparam logic [DIV_W-1:0] MASK = DIV_W'((64'd1 << SHV[i]) - 64'd1);
        assign fast_taps[i] = ((fast_q & MASK) == MASK);
    end

    assign fs_edge   = (pre_q == PRE_W'(SLOW_RATIO - 1));
    assign slow_tick = fs_edge && (&slow_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            slow_q <= '0;
        end else if (fs_edge) begin
            pre_q  <= '0;
            slow_q <= slow_q + 1'b1;
        end else begin
            pre_q  <= pre_q + 1'b1;
        end
    end

    assign tick = pick_tick(fast_taps, slow_tick, sel, div_mode, low_power);

    // R6: every source is at least two clocks apart
    a_r6_tick_spaced: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/cmt_stage.sv
module cmt_stage #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] val,
    output logic         carry
);
    always_ff @(posedge clk) begin
        if (rst || clr) val <= '0;
        else if (inc)   val <= val + 1'b1;
    end

    assign carry = inc && (&val);

    // R3: a stage moves only on its own increment or a clear
    a_r3_stage_hold: assert property (@(posedge clk) disable iff (rst)
        (!inc && !clr) |=> $stable(val));

endmodule

// File: rtl/cmt_match_reg.sv
module cmt_match_reg
    import cmt_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_hi,
    input  logic        wr_lo,
    input  logic [7:0]  wr_data,
    input  logic [15:0] count,
    output logic        hit
);
    match_bytes_t m_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= '{hi: 8'hFF, lo: 8'hFF};
        end else begin
            if (wr_hi) m_q.hi <= wr_data;
            if (wr_lo) m_q.lo <= wr_data;
        end
    end

    assign hit = (count == m_q);

    // R5: a written byte is in force on the very next cycle
    a_r5_hi_write: assert property (@(posedge clk) disable iff (rst)
        wr_hi |=> (m_q.hi == $past(wr_data)));
    a_r5_lo_write: assert property (@(posedge clk) disable iff (rst)
        wr_lo |=> (m_q.lo == $past(wr_data)));

endmodule

// File: rtl/cascade_match_timer.sv
module cascade_match_timer
    import cmt_pkg::*;
#(
    parameter int unsigned STAGE_W    = 8,
    parameter int unsigned SH0        = 11,
    parameter int unsigned SH1        = 7,
    parameter int unsigned SH2        = 5,
    parameter int unsigned SH3        = 3,
    parameter int unsigned SLOW_RATIO = 488
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        run_en,
    input  logic [1:0]  src_sel,
    input  logic        div_mode,
    input  logic        low_power,
    input  logic        wr_hi,
    input  logic        wr_lo,
    input  logic [7:0]  wr_data,
    input  logic        irq_clr,
    output logic        irq_pulse,
    output logic        irq_flag,
    output logic [15:0] count
);
    localparam int unsigned COUNT_W = 16;
    localparam int unsigned NSTAGE  = COUNT_W / STAGE_W;

    logic              tick;
    logic              hit;
    logic              match_evt;
    logic              clr_all;
    logic [NSTAGE:0]   inc_chain;
    logic              irq_q;
    logic              flag_q;

    cmt_prescaler #(
        .SH0(SH0), .SH1(SH1), .SH2(SH2), .SH3(SH3),
        .SLOW_RATIO(SLOW_RATIO), .SLOW_SH(3)
    ) u_pre (
        .clk(clk), .rst(rst), .sel(src_sel_e'(src_sel)),
        .div_mode(div_mode), .low_power(low_power), .tick(tick)
    );

    cmt_match_reg u_match (
        .clk(clk), .rst(rst), .wr_hi(wr_hi), .wr_lo(wr_lo),
        .wr_data(wr_data), .count(count), .hit(hit)
    );

    assign match_evt    = run_en && tick && hit;
    assign clr_all      = !run_en || match_evt;
    assign inc_chain[0] = run_en && tick && !hit;

    for (genvar s = 0; s < NSTAGE; s++) begin : g_stage
        cmt_stage #(.W(STAGE_W)) u_stage (
            .clk(clk), .rst(rst), .clr(clr_all), .inc(inc_chain[s]),
            .val(count[s*STAGE_W +: STAGE_W]), .carry(inc_chain[s+1])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q  <= 1'b0;
            flag_q <= 1'b0;
        end else begin
            irq_q <= match_evt;
            if (match_evt)    flag_q <= 1'b1;
            else if (irq_clr) flag_q <= 1'b0;
        end
    end

    assign irq_pulse = irq_q;
    assign irq_flag  = flag_q;

    // R2: stopped timer sits at zero
    a_r2_stop_zero: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> (count == '0));
    // R3: no tick, no movement
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        (run_en && !tick) |=> $stable(count));
    // R4: pulse lasts one cycle and coincides with a cleared count
    a_r4_pulse_single: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |=> !irq_pulse);
    a_r4_pulse_at_zero: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> (count == '0));
    // R9: flag is up whenever a pulse is
    a_r9_flag_on_pulse: assert property (@(posedge clk) disable iff (rst)
        irq_pulse |-> irq_flag);
    // R10: carry out of the top stage lands on zero
    a_r10_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
        inc_chain[NSTAGE] |=> (count == '0));

endmodule

// File: tb/tb_cascade_match_timer.sv
module tb_cascade_match_timer;
    localparam int SH0 = 11, SH1 = 7, SH2 = 5, SH3 = 1, SLOW_RATIO = 4;
    localparam int SLOW_P = SLOW_RATIO * 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic run_en = 1'b0;
    logic [1:0] src_sel = 2'd3;
    logic div_mode = 1'b0, low_power = 1'b0;
    logic wr_hi = 1'b0, wr_lo = 1'b0, irq_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic irq_pulse, irq_flag;
    logic [15:0] count;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    cascade_match_timer #(
        .STAGE_W(8), .SH0(SH0), .SH1(SH1), .SH2(SH2), .SH3(SH3),
        .SLOW_RATIO(SLOW_RATIO)
    ) dut (
        .clk(clk), .rst(rst), .run_en(run_en), .src_sel(src_sel),
        .div_mode(div_mode), .low_power(low_power), .wr_hi(wr_hi),
        .wr_lo(wr_lo), .wr_data(wr_data), .irq_clr(irq_clr),
        .irq_pulse(irq_pulse), .irq_flag(irq_flag), .count(count)
    );

    // Behavioural reference model
    int m_fast, m_pre, m_sdiv, m_count, m_match;
    bit m_pulse, m_flag;

    function automatic bit tap(int n, int sh);
        return ((n + 1) % (1 << sh)) == 0;
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_fast = 0; m_pre = 0; m_sdiv = 0; m_count = 0;
            m_match = 16'hFFFF; m_pulse = 0; m_flag = 0;
        end else begin
            bit slow_edge, slow_t, t;
            slow_edge = (m_pre == SLOW_RATIO - 1);
            slow_t = slow_edge && (m_sdiv == 7);
            if (low_power)          t = (src_sel == 0) ? slow_t : 1'b0;
            else if (src_sel == 0)  t = div_mode ? slow_t : tap(m_fast, SH0);
            else if (src_sel == 1)  t = tap(m_fast, SH1);
            else if (src_sel == 2)  t = tap(m_fast, SH2);
            else                    t = tap(m_fast, SH3);
            m_pulse = 0;
            if (!run_en) m_count = 0;
            else if (t) begin
                if (m_count == m_match) begin m_count = 0; m_pulse = 1; end
                else m_count = (m_count + 1) % 65536;
            end
            if (m_pulse) m_flag = 1;
            else if (irq_clr) m_flag = 0;
            if (wr_hi) m_match = (m_match & 'hFF) | (int'(wr_data) << 8);
            if (wr_lo) m_match = (m_match & 'hFF00) | int'(wr_data);
            m_fast = (m_fast + 1) % (1 << SH0);
            if (slow_edge) begin m_pre = 0; m_sdiv = (m_sdiv + 1) % 8; end
            else m_pre = m_pre + 1;
        end
        if (cyc > 199000 && !done) begin
            done = 1;
            fails++; tests++;
            $display("FAIL R3 watchdog expired act=%0d exp<=%0d", cyc, 199000);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Cycle-by-cycle comparison (R3, R4, R9)
    always @(negedge clk) begin
        if (!rst && !done) begin
            tests++;
            if (count !== 16'(m_count)) begin
                fails++;
                $display("FAIL R3 count act=%h exp=%h", count, m_count);
            end
            if (irq_pulse !== m_pulse) begin
                fails++;
                $display("FAIL R4 irq_pulse act=%b exp=%b", irq_pulse, m_pulse);
            end
            if (irq_flag !== m_flag) begin
                fails++;
                $display("FAIL R9 irq_flag act=%b exp=%b", irq_flag, m_flag);
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic write_match(int v);
        @(negedge clk); wr_hi = 1; wr_data = 8'(v >> 8);
        @(negedge clk); wr_hi = 0; wr_lo = 1; wr_data = 8'(v);
        @(negedge clk); wr_lo = 0;
    endtask

    task automatic wait_pulse();
        do @(negedge clk); while (!irq_pulse);
    endtask

    task automatic gap_check(int exp, string tag);
        int n;
        wait_pulse();
        wait_pulse();
        n = 0;
        do begin @(negedge clk); n++; end while (!irq_pulse);
        check(n == exp, tag, n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        check(count == 0 && !irq_pulse && !irq_flag, "R1 reset outputs", int'(count), 0);

        // R4 / R6 fast taps with match 5
        write_match(5);
        src_sel = 3; run_en = 1;
        gap_check(6 * (1 << SH3), "R6 sel3 gap (R4)");
        check(irq_flag == 1, "R9 flag set", irq_flag, 1);
        @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
        check(irq_flag == 0, "R9 flag cleared", irq_flag, 0);
        src_sel = 2; gap_check(6 * (1 << SH2), "R6 sel2 gap");
        src_sel = 1; gap_check(6 * (1 << SH1), "R6 sel1 gap");
        write_match(1);
        src_sel = 0; gap_check(2 * (1 << SH0), "R6 sel0 gap");

        // R7 divider mode
        div_mode = 1; gap_check(2 * SLOW_P, "R7 slow tick gap");
        // R8 low power, select 0 then select 2
        div_mode = 0; low_power = 1;
        gap_check(2 * SLOW_P, "R8 low power sel0 gap");
        src_sel = 2;
        @(negedge clk);
        begin
            logic [15:0] held = count;
            repeat (600) @(negedge clk);
            check(count == held, "R8 low power sel2 frozen", int'(count), int'(held));
        end
        low_power = 0;

        // R2 stop
        run_en = 0; @(negedge clk);
        check(count == 0, "R2 stop clears", int'(count), 0);
        repeat (200) @(negedge clk);
        check(count == 0 && !irq_pulse, "R2 stop holds", int'(count), 0);

        // R9 set wins over clear
        src_sel = 3; write_match(3); run_en = 1; irq_clr = 1;
        wait_pulse();
        check(irq_flag == 1, "R9 set wins", irq_flag, 1);
        @(negedge clk);
        check(irq_flag == 0, "R9 clear after pulse", irq_flag, 0);
        irq_clr = 0;

        // R5 run-time rewrite
        run_en = 0; write_match(16'h0100); run_en = 1;
        do @(negedge clk); while (count != 16'h0020);
        write_match(16'h0030);
        begin
            int last = 0;
            while (!irq_pulse) begin last = int'(count); @(negedge clk); end
            check(last == 16'h30, "R5 new match used", last, 16'h30);
        end

        // R10 match below count wraps
        run_en = 0; write_match(16'h00C8); run_en = 1;
        do @(negedge clk); while (count != 16'h0080);
        write_match(16'h0040);
        begin
            bit top = 0;
            while (!irq_pulse) begin
                if (count == 16'hFFFF) top = 1;
                @(negedge clk);
            end
            check(top == 1, "R10 wrap through 0xFFFF", top, 1);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule